// File: doc/BRIEF.md
# Immediate Operand and Logical Flag Unit

This unit is the logical slice of a 32-bit integer core's execute stage. Each accepted operation has two operands. The first is a register operand. The second is chosen by a select bit. It is either an encoded 12-bit immediate or a value that an external register shifter has already produced, together with that shifter's carry. The unit applies one of eight bitwise operations. It returns a registered result, a register write-enable and the next NZCV flag set.

When the immediate path is used, no shifter is involved. The unit expands the immediate itself and derives the carry that a shifter would have reported. A zero rotate field passes the old C flag through unchanged. A non-zero rotate field reports the top bit of the rotated value. The test checks the rotate field directly, so an immediate with a set top byte bit and no rotation, such as 0x80, can never leak a wrong carry.

Top module: `logic_flag_unit`

## Requirements
- R1: The immediate field imm12_i is expanded as follows: bits [7:0] are zero-extended to 32 bits and rotated right by twice the value of bits [11:8].
- R2: With imm_sel_i=1 and a rotate field of zero, the carry written to C on a flag update equals the incoming C (flags_i[1]).
- R3: With imm_sel_i=1 and a non-zero rotate field, the carry written to C equals bit 31 of the expanded immediate.
- R4: With imm_sel_i=0, the second operand is shift_data_i and the carry is shift_carry_i, unchanged.
- R5: Opcodes (opcode_i): 0000 AND and 1000 TST give a&b; 0001 EOR and 1001 TEQ give a^b; 1100 ORR gives a|b; 1101 MOV gives b; 1110 BIC gives a&~b; 1111 MVN gives ~b. Here a=reg_op_i and b is the second operand.
- R6: Flags are packed as flags[3]=N, [2]=Z, [1]=C, [0]=V. On an update, N is result bit 31, Z is set when the result is zero, C is the operand carry, and V is kept.
- R7: A non-test logical opcode with set_flags_i=0 leaves flags_o equal to flags_i.
- R8: TST and TEQ always update the flags and never raise wr_en_o. The other six logical opcodes raise wr_en_o.
- R9: Any other opcode gives wr_en_o=0, result_o=0 and flags_o equal to flags_i.
- R10: Outputs appear one clock after valid_i, with valid_o high. wr_en_o is never high while valid_o is low.
- R11: While rst_ni is low, valid_o, wr_en_o, result_o and flags_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation accepted this cycle |
| opcode_i | input | 4 | Logical opcode |
| set_flags_i | input | 1 | Update flags for non-test opcodes |
| imm_sel_i | input | 1 | 1: immediate operand, 0: shifter operand |
| imm12_i | input | 12 | Rotate field [11:8] and 8-bit value [7:0] |
| reg_op_i | input | 32 | First (register) operand |
| shift_data_i | input | 32 | External shifter result |
| shift_carry_i | input | 1 | External shifter carry-out |
| flags_i | input | 4 | Current NZCV |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Register write-enable |
| flags_o | output | 4 | Next NZCV |

## Verification
The assertions treat the data inputs as relevant only in a cycle with valid_i high. They compare each registered output against the inputs of that one cycle, so they assume a single-cycle issue with no holding of operands. The stimulus follows this rule. It changes every input at the falling edge, so the values are settled long before the capturing edge. It raises valid_i only for one operation at a time. It mixes back-to-back issues with idle gaps and walks the full 4-bit opcode space, including the undefined codes. Carry cases are aimed at rotate-zero immediates with bit 7 set, and at non-zero rotates that do and do not land a one in bit 31.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 8;
  localparam int unsigned ROT_W  = 4;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_EOR = 4'b0001,
    OP_TST = 4'b1000,
    OP_TEQ = 4'b1001,
    OP_ORR = 4'b1100,
    OP_MOV = 4'b1101,
    OP_BIC = 4'b1110,
    OP_MVN = 4'b1111
  } lfu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/lfu_imm_expand.sv
module lfu_imm_expand #(
  parameter int unsigned DATA_W = lfu_pkg::DATA_W,
  parameter int unsigned IMM_W  = lfu_pkg::IMM_W,
  parameter int unsigned ROT_W  = lfu_pkg::ROT_W
) (
  input  logic [ROT_W+IMM_W-1:0] imm_i,
  input  logic                   c_i,
  output logic [DATA_W-1:0]      value_o,
  output logic                   carry_o
);
  localparam int unsigned AMT_W = ROT_W + 1;

  logic [ROT_W-1:0]  rot;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] ext;

  assign rot = imm_i[ROT_W+IMM_W-1:IMM_W];
  assign amt = {rot, 1'b0};
  assign ext = {{(DATA_W-IMM_W){1'b0}}, imm_i[IMM_W-1:0]};

  always_comb begin
    value_o = '0;
    for (int j = 0; j < DATA_W; j++) begin
      value_o[j] = ext[(j + int'(amt)) % DATA_W];
    end
  end

  // zero test on the rotate field itself, not on a derived amount
  assign carry_o = (rot == '0) ? c_i : value_o[DATA_W-1];
endmodule

// File: rtl/lfu_operand_sel.sv
module lfu_operand_sel #(
  parameter int unsigned DATA_W = lfu_pkg::DATA_W,
  parameter int unsigned IMM_W  = lfu_pkg::IMM_W,
  parameter int unsigned ROT_W  = lfu_pkg::ROT_W
) (
  input  logic                   imm_sel_i,
  input  logic [ROT_W+IMM_W-1:0] imm_i,
  input  logic [DATA_W-1:0]      shift_data_i,
  input  logic                   shift_carry_i,
  input  logic                   c_i,
  output logic [DATA_W-1:0]      op_o,
  output logic                   carry_o
);
  logic [DATA_W-1:0] imm_val;
  logic              imm_carry;

  lfu_imm_expand #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm_i  (imm_i),
    .c_i    (c_i),
    .value_o(imm_val),
    .carry_o(imm_carry)
  );

  assign op_o    = imm_sel_i ? imm_val   : shift_data_i;
  assign carry_o = imm_sel_i ? imm_carry : shift_carry_i;
endmodule

// File: rtl/lfu_logic_core.sv
module lfu_logic_core #(
  parameter int unsigned DATA_W = lfu_pkg::DATA_W
) (
  input  logic [3:0]        op_i,
  input  logic              set_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  lfu_pkg::nzcv_t    flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o,
  output logic              upd_o,
  output lfu_pkg::nzcv_t    flags_o
);
  import lfu_pkg::*;

  logic is_logic;
  logic is_test;

  always_comb begin
    res_o    = '0;
    is_logic = 1'b1;
    case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        is_logic = 1'b0;
    endcase
    is_test = (op_i == OP_TST) || (op_i == OP_TEQ);
    we_o    = is_logic && !is_test;
    upd_o   = is_logic && (is_test || set_i);
    flags_o = flags_i;
    if (upd_o) begin
      flags_o.n = res_o[DATA_W-1];
      flags_o.z = (res_o == '0);
      flags_o.c = carry_i;
    end
  end
endmodule

// File: rtl/logic_flag_unit.sv
module logic_flag_unit #(
  parameter int unsigned DATA_W = lfu_pkg::DATA_W,
  parameter int unsigned IMM_W  = lfu_pkg::IMM_W,
  parameter int unsigned ROT_W  = lfu_pkg::ROT_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [3:0]             opcode_i,
  input  logic                   set_flags_i,
  input  logic                   imm_sel_i,
  input  logic [ROT_W+IMM_W-1:0] imm12_i,
  input  logic [DATA_W-1:0]      reg_op_i,
  input  logic [DATA_W-1:0]      shift_data_i,
  input  logic                   shift_carry_i,
  input  logic [3:0]             flags_i,
  output logic                   valid_o,
  output logic [DATA_W-1:0]      result_o,
  output logic                   wr_en_o,
  output logic [3:0]             flags_o
);
  import lfu_pkg::*;

  logic [DATA_W-1:0] op_b;
  logic              op_carry;
  logic [DATA_W-1:0] res_d;
  logic              we_d;
  logic              upd_d;
  nzcv_t             flags_cur;
  nzcv_t             flags_d;

  assign flags_cur = nzcv_t'(flags_i);

  lfu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_sel (
    .imm_sel_i    (imm_sel_i),
    .imm_i        (imm12_i),
    .shift_data_i (shift_data_i),
    .shift_carry_i(shift_carry_i),
    .c_i          (flags_cur.c),
    .op_o         (op_b),
    .carry_o      (op_carry)
  );

  lfu_logic_core #(.DATA_W(DATA_W)) u_core (
    .op_i   (opcode_i),
    .set_i  (set_flags_i),
    .a_i    (reg_op_i),
    .b_i    (op_b),
    .carry_i(op_carry),
    .flags_i(flags_cur),
    .res_o  (res_d),
    .we_o   (we_d),
    .upd_o  (upd_d),
    .flags_o(flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i & we_d;
      if (valid_i) begin
        result_o <= res_d;
        flags_o  <= flags_d;
      end
    end
  end

  p_zero_rot_carry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && imm_sel_i && imm12_i[ROT_W+IMM_W-1:IMM_W] == '0 && upd_d
    |=> flags_o[1] == $past(flags_i[1]));

  p_reg_carry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !imm_sel_i && upd_d |=> flags_o[1] == $past(shift_carry_i));

  p_v_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o[0] == $past(flags_i[0]));

  p_z_tracks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && upd_d |=> flags_o[2] == (result_o == '0));

  p_no_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !set_flags_i && opcode_i != OP_TST && opcode_i != OP_TEQ
    |=> flags_o == $past(flags_i));

  p_test_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (opcode_i == OP_TST || opcode_i == OP_TEQ) |=> !wr_en_o);

  p_undef_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !(opcode_i inside {OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR, OP_MOV, OP_BIC, OP_MVN})
    |=> !wr_en_o && result_o == '0 && flags_o == $past(flags_i));

  p_idle_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !wr_en_o);
endmodule

// File: tb/logic_flag_unit_tb.sv
module logic_flag_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  opcode = '0;
  logic        set_f = 1'b0;
  logic        imm_sel = 1'b0;
  logic [11:0] imm12 = '0;
  logic [31:0] reg_op = '0;
  logic [31:0] sh_data = '0;
  logic        sh_carry = 1'b0;
  logic [3:0]  flags_in = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_o;

  int tests = 0;
  int fails = 0;

  typedef struct packed {
    logic [31:0] res;
    logic        we;
    logic [3:0]  fl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  logic_flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .opcode_i(opcode),
    .set_flags_i(set_f), .imm_sel_i(imm_sel), .imm12_i(imm12),
    .reg_op_i(reg_op), .shift_data_i(sh_data), .shift_carry_i(sh_carry),
    .flags_i(flags_in), .valid_o(valid_o), .result_o(result_o),
    .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model from the requirements: R1 expansion, R2/R3/R4 carry, R5..R9 ops and flags
  function automatic exp_t model(input logic [3:0] op, input logic s, input logic isel,
                                 input logic [11:0] imm, input logic [31:0] a,
                                 input logic [31:0] sh, input logic shc, input logic [3:0] fl);
    exp_t        e;
    logic [31:0] v;
    logic [31:0] b;
    logic        c;
    int          amt;
    logic        legal;
    logic        test;
    amt = 2 * int'(imm[11:8]);
    v = {24'h0, imm[7:0]};
    for (int k = 0; k < amt; k++) v = {v[0], v[31:1]};
    b = isel ? v : sh;
    c = isel ? ((imm[11:8] == 4'h0) ? fl[1] : v[31]) : shc;
    legal = 1'b1;
    test = (op == 4'b1000) || (op == 4'b1001);
    case (op)
      4'b0000, 4'b1000: e.res = a & b;
      4'b0001, 4'b1001: e.res = a ^ b;
      4'b1100: e.res = a | b;
      4'b1101: e.res = b;
      4'b1110: e.res = a & ~b;
      4'b1111: e.res = ~b;
      default: begin e.res = '0; legal = 1'b0; end
    endcase
    e.we = legal && !test;
    e.fl = fl;
    if (legal && (test || s)) e.fl = {e.res[31], e.res == 32'h0, c, fl[0]};
    return e;
  endfunction

  task automatic send(input logic [3:0] op, input logic s, input logic isel,
                      input logic [11:0] imm, input logic [31:0] a, input logic [31:0] sh,
                      input logic shc, input logic [3:0] fl, input string tag);
    @(negedge clk);
    valid_i = 1'b1; opcode = op; set_f = s; imm_sel = isel; imm12 = imm;
    reg_op = a; sh_data = sh; sh_carry = shc; flags_in = fl;
    exp_q.push_back(model(op, s, isel, imm, a, sh, shc, fl));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid_i = 1'b0;
      opcode = 4'hx;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected valid_o", 32'd1, 32'd0);
      end else begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " result"}, result_o, e.res);
        check({"R8 ", t, " wr_en"}, {31'h0, wr_en_o}, {31'h0, e.we});
        check({"R6 ", t, " flags"}, {28'h0, flags_o}, {28'h0, e.fl});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid_o", {31'h0, valid_o}, 32'h0);
    check("R11 wr_en_o", {31'h0, wr_en_o}, 32'h0);
    check("R11 result_o", result_o, 32'h0);
    check("R11 flags_o", {28'h0, flags_o}, 32'h0);
    rst_n = 1'b1;
    idle(2);

    // R2 carry kept on TST with zero rotate (C was set by a prior compare)
    send(4'b1000, 1'b0, 1'b1, 12'h010, 32'h0000_0930, 32'h0, 1'b0, 4'b0010, "R2 tst_c_kept");
    // R2 imm 0x80, rotate zero: bit7 must not leak as carry
    send(4'b1101, 1'b1, 1'b1, 12'h080, 32'h0, 32'h0, 1'b1, 4'b0000, "R2 mov_0x80_c0");
    send(4'b1101, 1'b1, 1'b1, 12'h0FF, 32'h0, 32'h0, 1'b0, 4'b0011, "R2 mov_0xff_c1");
    // R3 non-zero rotate: bit31 of expanded value
    send(4'b1101, 1'b1, 1'b1, 12'h103, 32'h0, 32'h0, 1'b0, 4'b0000, "R3 R1 mov_c0000000");
    send(4'b0000, 1'b1, 1'b1, 12'h401, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'b0010, "R3 R1 and_bit24_c0");
    send(4'b1001, 1'b0, 1'b1, 12'hF81, 32'h0, 32'h0, 1'b0, 4'b0001, "R3 R1 teq_rot30");
    idle(1);
    send(4'b1111, 1'b1, 1'b1, 12'h8AB, 32'h0, 32'h0, 1'b1, 4'b0000, "R1 R5 mvn_rot16");
    // R4 register operand
    send(4'b1100, 1'b1, 1'b0, 12'h000, 32'h1234_0000, 32'h0000_5678, 1'b1, 4'b0000, "R4 orr_reg_c1");
    send(4'b0001, 1'b1, 1'b0, 12'hF00, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 4'b1110, "R4 eor_zero");
    send(4'b1110, 1'b1, 1'b0, 12'h000, 32'hF0F0_F0F0, 32'h00FF_00FF, 1'b1, 4'b0101, "R4 R5 bic_reg");
    idle(2);
    // R7 no flag update without S
    send(4'b0000, 1'b0, 1'b1, 12'h1FF, 32'h0, 32'h0, 1'b0, 4'b1011, "R7 and_nos");
    send(4'b1111, 1'b0, 1'b0, 12'h000, 32'h0, 32'hFFFF_FFFF, 1'b1, 4'b0100, "R7 mvn_nos");
    // R9 undefined opcodes
    for (int op = 2; op < 8; op++)
      send(op[3:0], 1'b1, 1'b1, 12'h2F0, 32'h5555_5555, 32'h1, 1'b1, 4'b1001, "R9 undef");
    send(4'b1010, 1'b1, 1'b0, 12'h000, 32'h1, 32'h1, 1'b0, 4'b0110, "R9 undef_a");
    send(4'b1011, 1'b1, 1'b0, 12'h000, 32'h1, 32'h1, 1'b0, 4'b0110, "R9 undef_b");
    // R5 every opcode, every rotate
    for (int r = 0; r < 16; r++) begin
      for (int op = 0; op < 16; op++) begin
        send(op[3:0], r[0], (r % 3) != 0, {r[3:0], 8'h80 | r[7:0]},
             32'h9E37_79B9 ^ (r * 32'h0101_0101), 32'h7F4A_7C15 + op, op[1], r[3:0],
             "R5 sweep");
      end
      idle(r % 2);
    end
    idle(3);
    // R10 idle: no write, no valid
    check("R10 idle valid_o", {31'h0, valid_o}, 32'h0);
    check("R10 idle wr_en_o", {31'h0, wr_en_o}, 32'h0);
    check("R10 queue drained", exp_q.size(), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule